// File: doc/BRIEF.md
# Exception and interrupt entry unit

This unit belongs to the control-status register section of a processor core. Every cycle it samples the hardware interrupt lines into a status field and masks them with a local enable mask. It then decides whether an interrupt may be taken and picks the line with the highest number. When it accepts an exception request, or takes an interrupt, it computes the handler address and, in the same step, updates the mode, saved-mode, return-address, cause and fault registers. It also drives a one-cycle redirect pulse together with the new fetch address.

There are three entry routes, and each keeps its state in its own registers. The ordinary route records the cause and the return address. The translation-refill route saves the mode into a separate set of registers and forces direct addressing. The debug route records a debug cause and a debug return address, and sets debug mode. A small control write port lets the surrounding register file load the privilege level, the interrupt enable, the vector-size field and the interrupt mask. If the same cycle also performs an entry, the entry's clearing of privilege and enable takes precedence.

Top module: `trap_entry_unit`

## Requirements
- R1: An ordinary interrupt entry happens only when the mode interrupt-enable bit is 1 and debug mode is 0. With the enable bit at 0 and no exception request, no redirect is produced.
- R2: The lines are registered into `irq_status` one cycle after they are driven. The pending set is `irq_status & irq_mask`, and with an empty pending set no interrupt is taken.
- R3: The vector number is the index of the highest-numbered bit in the pending set.
- R4: The vector spacing is 0 when `vec_size` is 0 and `(1 << vec_size) * 4` bytes otherwise. With size 0, every ordinary entry goes to `entry_base`.
- R5: An interrupt enters at `entry_base + (64 + vector) * spacing` and records cause major 0x00, sub 0. An ordinary exception enters at `entry_base + major * spacing`.
- R6: An ordinary entry copies the current privilege and enable into `save_plv`/`save_ie`, writes `cause_major`/`cause_sub`, and sets `ret_pc` to `cur_pc`.
- R7: An exception with `exc_refill` = 1 enters at `refill_base`. It saves privilege and enable into `rf_save_plv`/`rf_save_ie`, writes `cur_pc >> 2` into `rf_ret_pc`, sets `mode_da` = 1, `mode_pg` = 0 and `rf_active` = 1, and leaves `ret_pc` and the cause unchanged.
- R8: Every entry sets `mode_plv` = 0 and `mode_ie` = 0. Its `redirect_valid` pulse and register updates appear at the clock edge that accepts it.
- R9: A debug breakpoint (major 0x3F) sets `dbg_cause` = 1, `dbg_code` = 0xC, `dbg_ret_pc` = `cur_pc` and `dbg_active` = 1, and enters at `entry_base + 0x480`.
- R10: An interrupt taken while `dbg_active` = 1 and `mode_ie` = 1 sets `dbg_irq`, writes `dbg_ret_pc` and enters at `entry_base + 0x480`. It leaves `ret_pc` untouched.
- R11: Codes 0x0B, 0x0C, 0x0D, 0x0E, 0x0F, 0x10 and 0x12 load `bad_addr` with `cur_pc`. Codes 0x03 and 0x08 sub 0, and interrupts, keep `bad_insn`. Codes 0x01, 0x02, 0x04, 0x05, 0x06, 0x07 and 0x08 sub 1, plus all codes in the `bad_addr` group, load `bad_insn` with `fault_insn`.
- R12: Reset gives `redirect_pc` = 0x1C000000. It also gives privilege 0, enable 0, `mode_da` = 1, `mode_pg` = 0, `mode_datf` = `mode_datm` = 1, `vec_size` = 0, `irq_mask` = 0, `rf_active` = 0 and `dbg_active` = 0.
- R13: The following requests are unsupported: any major code not listed in R9 or R11, a nonzero sub on any code except 0x08, and 0x08 with sub above 1. Such a request pulses `req_error` and produces no redirect. It changes no saved, cause or fault register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_IRQ | Level-sensitive interrupt lines |
| exc_valid | input | 1 | Exception request strobe |
| exc_major | input | 6 | Major exception code |
| exc_sub | input | 2 | Exception subcode |
| exc_refill | input | 1 | Request uses the translation-refill route |
| cur_pc | input | XLEN | PC of the current instruction |
| fault_insn | input | INSN_W | Instruction word of the faulting instruction |
| entry_base | input | XLEN | Base handler address |
| refill_base | input | XLEN | Refill handler address |
| ctl_wr | input | 1 | Load the mode/config fields below |
| ctl_plv | input | 2 | Privilege level to load |
| ctl_ie | input | 1 | Interrupt enable to load |
| ctl_vs | input | VS_W | Vector-size field to load |
| ctl_lie | input | NUM_IRQ | Interrupt mask to load |
| redirect_valid | output | 1 | One-cycle entry pulse |
| redirect_pc | output | XLEN | Fetch address (reset PC after reset) |
| req_error | output | 1 | Unsupported request pulse |
| mode_plv | output | 2 | Current privilege level |
| mode_ie | output | 1 | Current interrupt enable |
| mode_da | output | 1 | Direct-address mode |
| mode_pg | output | 1 | Paged mode |
| mode_datf | output | 2 | Direct-access fetch memory type |
| mode_datm | output | 2 | Direct-access data memory type |
| vec_size | output | VS_W | Vector-size field |
| irq_mask | output | NUM_IRQ | Local interrupt enable mask |
| irq_status | output | NUM_IRQ | Registered interrupt lines |
| save_plv | output | 2 | Saved privilege, ordinary route |
| save_ie | output | 1 | Saved enable, ordinary route |
| cause_major | output | 6 | Recorded major code |
| cause_sub | output | 2 | Recorded subcode |
| ret_pc | output | XLEN | Ordinary return address |
| bad_addr | output | XLEN | Fault address |
| bad_insn | output | INSN_W | Fault instruction word |
| rf_save_plv | output | 2 | Saved privilege, refill route |
| rf_save_ie | output | 1 | Saved enable, refill route |
| rf_ret_pc | output | XLEN-2 | Refill return address (word index) |
| rf_active | output | 1 | Refill in progress |
| dbg_active | output | 1 | Debug mode |
| dbg_cause | output | 1 | Debug entry by breakpoint |
| dbg_irq | output | 1 | Debug entry by interrupt |
| dbg_code | output | 6 | Debug cause code |
| dbg_ret_pc | output | XLEN | Debug return address |

## Verification
An exception request is sampled at one rising edge, and its redirect and register updates are visible right after that same edge. The bench drives each request on a falling edge and reads the results on the next falling edge. An interrupt needs two edges: the first registers the lines into the status field, and the second takes the entry. The bench therefore steps twice after changing the lines, or once after a control write when the lines are already registered. It confirms that no redirect appears at the intermediate edge. An unsupported request, and the debug-route interrupt, are checked one edge after the request against register values that the bench tracked before it.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int CODE_W = 6;
  localparam int SUB_W  = 2;

  localparam logic [CODE_W-1:0] C_INT     = 6'h00;
  localparam logic [CODE_W-1:0] C_LD_INV  = 6'h01;
  localparam logic [CODE_W-1:0] C_ST_INV  = 6'h02;
  localparam logic [CODE_W-1:0] C_IF_INV  = 6'h03;
  localparam logic [CODE_W-1:0] C_MOD     = 6'h04;
  localparam logic [CODE_W-1:0] C_NO_RD   = 6'h05;
  localparam logic [CODE_W-1:0] C_NO_EX   = 6'h06;
  localparam logic [CODE_W-1:0] C_PG_PRIV = 6'h07;
  localparam logic [CODE_W-1:0] C_ADDR    = 6'h08;
  localparam logic [CODE_W-1:0] C_SYS     = 6'h0B;
  localparam logic [CODE_W-1:0] C_BRK     = 6'h0C;
  localparam logic [CODE_W-1:0] C_ILL     = 6'h0D;
  localparam logic [CODE_W-1:0] C_IPRIV   = 6'h0E;
  localparam logic [CODE_W-1:0] C_FP_OFF  = 6'h0F;
  localparam logic [CODE_W-1:0] C_BOUND   = 6'h10;
  localparam logic [CODE_W-1:0] C_FP_EXC  = 6'h12;
  localparam logic [CODE_W-1:0] C_DBG     = 6'h3F;

  typedef enum logic [1:0] {
    PATH_NONE,
    PATH_NORMAL,
    PATH_REFILL,
    PATH_DEBUG
  } path_e;

  typedef struct packed {
    logic ok;
    logic is_dbg;
    logic bad_addr;
    logic bad_insn;
  } cls_t;
endpackage

// File: rtl/trap_classify.sv
module trap_classify
  import trap_pkg::*;
(
  input  logic [CODE_W-1:0] major,
  input  logic [SUB_W-1:0]  sub,
  output cls_t              cls
);
  logic sub_zero;

  assign sub_zero = (sub == '0);

  always_comb begin
    cls = '0;
    case (major)
      C_LD_INV, C_ST_INV, C_MOD, C_NO_RD, C_NO_EX, C_PG_PRIV: begin
        cls.ok       = sub_zero;
        cls.bad_insn = 1'b1;
      end
      C_IF_INV: begin
        cls.ok = sub_zero;
      end
      C_ADDR: begin
        cls.ok       = (sub <= SUB_W'(1));
        cls.bad_insn = sub[0];
      end
      C_SYS, C_BRK, C_ILL, C_IPRIV, C_FP_OFF, C_FP_EXC, C_BOUND: begin
        cls.ok       = sub_zero;
        cls.bad_addr = 1'b1;
        cls.bad_insn = 1'b1;
      end
      C_DBG: begin
        cls.ok     = sub_zero;
        cls.is_dbg = 1'b1;
      end
      default: cls = '0;
    endcase
  end
endmodule

// File: rtl/trap_irq_sel.sv
module trap_irq_sel #(
  parameter int N     = 13,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     pend,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |pend;
    idx = '0;
    // ascending scan: the last set bit seen is the highest-numbered one
    for (int i = 0; i < N; i++) begin
      if (pend[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/trap_vec_calc.sv
module trap_vec_calc #(
  parameter int XLEN     = 32,
  parameter int VS_W     = 3,
  parameter int CODE_W   = 6,
  parameter int IDX_W    = 4,
  parameter int INT_BASE = 64
) (
  input  logic [XLEN-1:0]   base,
  input  logic [VS_W-1:0]   vs,
  input  logic              is_irq,
  input  logic [CODE_W-1:0] code,
  input  logic [IDX_W-1:0]  idx,
  output logic [XLEN-1:0]   addr
);
  localparam int NUM_W = $clog2(INT_BASE + (1 << IDX_W)) + 1;

  logic [NUM_W-1:0] num;
  logic [XLEN-1:0]  offs;

  always_comb begin
    num = is_irq ? (NUM_W'(INT_BASE) + NUM_W'(idx)) : NUM_W'(code);
    if (vs == '0) offs = '0;
    else          offs = XLEN'(num) << (XLEN'(vs) + XLEN'(2));
    addr = base + offs;
  end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter int              INSN_W     = 32,
  parameter int              NUM_IRQ    = 13,
  parameter int              VS_W       = 3,
  parameter int              INT_BASE   = 64,
  parameter logic [XLEN-1:0] RESET_PC   = 32'h1C00_0000,
  parameter logic [XLEN-1:0] DBG_OFFSET = 32'h0000_0480,
  parameter logic [5:0]      DBG_CODE   = 6'h0C
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_IRQ-1:0]  irq_in,
  input  logic                exc_valid,
  input  logic [5:0]          exc_major,
  input  logic [1:0]          exc_sub,
  input  logic                exc_refill,
  input  logic [XLEN-1:0]     cur_pc,
  input  logic [INSN_W-1:0]   fault_insn,
  input  logic [XLEN-1:0]     entry_base,
  input  logic [XLEN-1:0]     refill_base,
  input  logic                ctl_wr,
  input  logic [1:0]          ctl_plv,
  input  logic                ctl_ie,
  input  logic [VS_W-1:0]     ctl_vs,
  input  logic [NUM_IRQ-1:0]  ctl_lie,
  output logic                redirect_valid,
  output logic [XLEN-1:0]     redirect_pc,
  output logic                req_error,
  output logic [1:0]          mode_plv,
  output logic                mode_ie,
  output logic                mode_da,
  output logic                mode_pg,
  output logic [1:0]          mode_datf,
  output logic [1:0]          mode_datm,
  output logic [VS_W-1:0]     vec_size,
  output logic [NUM_IRQ-1:0]  irq_mask,
  output logic [NUM_IRQ-1:0]  irq_status,
  output logic [1:0]          save_plv,
  output logic                save_ie,
  output logic [5:0]          cause_major,
  output logic [1:0]          cause_sub,
  output logic [XLEN-1:0]     ret_pc,
  output logic [XLEN-1:0]     bad_addr,
  output logic [INSN_W-1:0]   bad_insn,
  output logic [1:0]          rf_save_plv,
  output logic                rf_save_ie,
  output logic [XLEN-3:0]     rf_ret_pc,
  output logic                rf_active,
  output logic                dbg_active,
  output logic                dbg_cause,
  output logic                dbg_irq,
  output logic [5:0]          dbg_code,
  output logic [XLEN-1:0]     dbg_ret_pc
);
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic [NUM_IRQ-1:0] pend;
  logic               pend_any;
  logic [IDX_W-1:0]   pend_idx;
  cls_t               cls;
  logic               irq_ok;
  logic               take_irq;
  logic               reject;
  path_e              path;
  logic [XLEN-1:0]    vec_addr;
  logic [XLEN-1:0]    next_pc;

  assign pend = irq_status & irq_mask;

  trap_irq_sel #(.N(NUM_IRQ), .IDX_W(IDX_W)) u_sel (
    .pend (pend),
    .any  (pend_any),
    .idx  (pend_idx)
  );

  trap_classify u_cls (
    .major (exc_major),
    .sub   (exc_sub),
    .cls   (cls)
  );

  // an interrupt needs the global enable; debug mode reroutes it
  assign irq_ok   = mode_ie && pend_any;
  assign take_irq = !exc_valid && irq_ok;

  always_comb begin
    path   = PATH_NONE;
    reject = 1'b0;
    if (exc_valid) begin
      if (!cls.ok)         reject = 1'b1;
      else if (cls.is_dbg) path   = PATH_DEBUG;
      else if (exc_refill) path   = PATH_REFILL;
      else                 path   = PATH_NORMAL;
    end else if (irq_ok) begin
      path = dbg_active ? PATH_DEBUG : PATH_NORMAL;
    end
  end

  trap_vec_calc #(
    .XLEN(XLEN), .VS_W(VS_W), .CODE_W(CODE_W), .IDX_W(IDX_W), .INT_BASE(INT_BASE)
  ) u_vec (
    .base   (entry_base),
    .vs     (vec_size),
    .is_irq (take_irq),
    .code   (exc_major),
    .idx    (pend_idx),
    .addr   (vec_addr)
  );

  always_comb begin
    case (path)
      PATH_NORMAL: next_pc = vec_addr;
      PATH_REFILL: next_pc = refill_base;
      PATH_DEBUG:  next_pc = entry_base + DBG_OFFSET;
      default:     next_pc = redirect_pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_valid <= 1'b0;
      redirect_pc    <= RESET_PC;
      req_error      <= 1'b0;
      mode_plv       <= 2'd0;
      mode_ie        <= 1'b0;
      mode_da        <= 1'b1;
      mode_pg        <= 1'b0;
      mode_datf      <= 2'd1;
      mode_datm      <= 2'd1;
      vec_size       <= '0;
      irq_mask       <= '0;
      irq_status     <= '0;
      save_plv       <= 2'd0;
      save_ie        <= 1'b0;
      cause_major    <= '0;
      cause_sub      <= '0;
      ret_pc         <= '0;
      bad_addr       <= '0;
      bad_insn       <= '0;
      rf_save_plv    <= 2'd0;
      rf_save_ie     <= 1'b0;
      rf_ret_pc      <= '0;
      rf_active      <= 1'b0;
      dbg_active     <= 1'b0;
      dbg_cause      <= 1'b0;
      dbg_irq        <= 1'b0;
      dbg_code       <= '0;
      dbg_ret_pc     <= '0;
    end else begin
      irq_status     <= irq_in;
      req_error      <= reject;
      redirect_valid <= (path != PATH_NONE);
      redirect_pc    <= next_pc;

      if (ctl_wr) begin
        mode_plv <= ctl_plv;
        mode_ie  <= ctl_ie;
        vec_size <= ctl_vs;
        irq_mask <= ctl_lie;
      end

      if (exc_valid && cls.ok && !cls.is_dbg) begin
        if (cls.bad_addr) bad_addr <= cur_pc;
        if (cls.bad_insn) bad_insn <= fault_insn;
      end

      case (path)
        PATH_NORMAL: begin
          save_plv    <= mode_plv;
          save_ie     <= mode_ie;
          cause_major <= take_irq ? C_INT : exc_major;
          cause_sub   <= take_irq ? '0 : exc_sub;
          ret_pc      <= cur_pc;
        end
        PATH_REFILL: begin
          rf_save_plv <= mode_plv;
          rf_save_ie  <= mode_ie;
          rf_ret_pc   <= cur_pc[XLEN-1:2];
          rf_active   <= 1'b1;
          mode_da     <= 1'b1;
          mode_pg     <= 1'b0;
        end
        PATH_DEBUG: begin
          dbg_ret_pc <= cur_pc;
          dbg_active <= 1'b1;
          if (take_irq) begin
            dbg_irq <= 1'b1;
          end else begin
            dbg_cause <= 1'b1;
            dbg_code  <= DBG_CODE;
          end
        end
        default: ;
      endcase

      if (path != PATH_NONE) begin
        mode_plv <= 2'd0;
        mode_ie  <= 1'b0;
      end
    end
  end

  // R8: any entry leaves privilege and enable at zero
  a_r8_entry_clears_mode: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |-> (mode_plv == 2'd0) && !mode_ie);

  // R1: without the enable and without an exception there is no entry
  a_r1_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    (!$past(mode_ie) && !$past(exc_valid)) |-> !redirect_valid);

  // R3: selected vector is the top pending bit
  a_r3_top_bit: assert property (@(posedge clk) disable iff (rst)
    pend_any |-> ((pend >> pend_idx) == NUM_IRQ'(1)));

  // R13: a rejected request redirects nothing and keeps the return address
  a_r13_error_quiet: assert property (@(posedge clk) disable iff (rst)
    req_error |-> !redirect_valid && $stable(ret_pc));

  // R9: debug mode is entered at the fixed debug offset
  a_r9_debug_target: assert property (@(posedge clk) disable iff (rst)
    $rose(dbg_active) |-> redirect_valid && (redirect_pc == $past(entry_base) + DBG_OFFSET));

  // R7: refill entry forces direct addressing and the refill target
  a_r7_refill_mode: assert property (@(posedge clk) disable iff (rst)
    $rose(rf_active) |-> mode_da && !mode_pg && (redirect_pc == $past(refill_base)));
endmodule

// File: tb/sim_trap_entry_unit.sv
module sim_trap_entry_unit;
  localparam int XLEN = 32;
  localparam int NIRQ = 13;
  localparam logic [31:0] BASE = 32'h9000_0000;
  localparam logic [31:0] RBASE = 32'h9100_0000;

  logic clk = 0;
  logic rst = 1;
  logic [NIRQ-1:0] irq_in = '0;
  logic exc_valid = 0;
  logic [5:0] exc_major = '0;
  logic [1:0] exc_sub = '0;
  logic exc_refill = 0;
  logic [31:0] cur_pc = '0;
  logic [31:0] fault_insn = '0;
  logic ctl_wr = 0;
  logic [1:0] ctl_plv = '0;
  logic ctl_ie = 0;
  logic [2:0] ctl_vs = '0;
  logic [NIRQ-1:0] ctl_lie = '0;

  logic redirect_valid, req_error, mode_ie, mode_da, mode_pg, save_ie;
  logic rf_save_ie, rf_active, dbg_active, dbg_cause, dbg_irq;
  logic [31:0] redirect_pc, ret_pc, bad_addr, bad_insn, dbg_ret_pc;
  logic [29:0] rf_ret_pc;
  logic [1:0] mode_plv, mode_datf, mode_datm, save_plv, cause_sub, rf_save_plv;
  logic [2:0] vec_size;
  logic [NIRQ-1:0] irq_mask, irq_status;
  logic [5:0] cause_major, dbg_code;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] m_ba, m_bi, m_ret;

  always #2 clk = ~clk;

  trap_entry_unit u0 (
    .clk(clk), .rst(rst), .irq_in(irq_in), .exc_valid(exc_valid),
    .exc_major(exc_major), .exc_sub(exc_sub), .exc_refill(exc_refill),
    .cur_pc(cur_pc), .fault_insn(fault_insn), .entry_base(BASE),
    .refill_base(RBASE), .ctl_wr(ctl_wr), .ctl_plv(ctl_plv), .ctl_ie(ctl_ie),
    .ctl_vs(ctl_vs), .ctl_lie(ctl_lie), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .req_error(req_error), .mode_plv(mode_plv),
    .mode_ie(mode_ie), .mode_da(mode_da), .mode_pg(mode_pg),
    .mode_datf(mode_datf), .mode_datm(mode_datm), .vec_size(vec_size),
    .irq_mask(irq_mask), .irq_status(irq_status), .save_plv(save_plv),
    .save_ie(save_ie), .cause_major(cause_major), .cause_sub(cause_sub),
    .ret_pc(ret_pc), .bad_addr(bad_addr), .bad_insn(bad_insn),
    .rf_save_plv(rf_save_plv), .rf_save_ie(rf_save_ie), .rf_ret_pc(rf_ret_pc),
    .rf_active(rf_active), .dbg_active(dbg_active), .dbg_cause(dbg_cause),
    .dbg_irq(dbg_irq), .dbg_code(dbg_code), .dbg_ret_pc(dbg_ret_pc)
  );

  // table entry: {major[12:7], sub[6:5], vs[4:2], loads_bad_addr[1], loads_bad_insn[0]}
  localparam logic [12:0] TBL [16] = '{
    {6'h01, 2'd0, 3'd1, 1'b0, 1'b1},
    {6'h02, 2'd0, 3'd2, 1'b0, 1'b1},
    {6'h03, 2'd0, 3'd3, 1'b0, 1'b0},
    {6'h04, 2'd0, 3'd7, 1'b0, 1'b1},
    {6'h05, 2'd0, 3'd0, 1'b0, 1'b1},
    {6'h06, 2'd0, 3'd1, 1'b0, 1'b1},
    {6'h07, 2'd0, 3'd2, 1'b0, 1'b1},
    {6'h08, 2'd0, 3'd3, 1'b0, 1'b0},
    {6'h08, 2'd1, 3'd4, 1'b0, 1'b1},
    {6'h0B, 2'd0, 3'd1, 1'b1, 1'b1},
    {6'h0C, 2'd0, 3'd2, 1'b1, 1'b1},
    {6'h0D, 2'd0, 3'd3, 1'b1, 1'b1},
    {6'h0E, 2'd0, 3'd4, 1'b1, 1'b1},
    {6'h0F, 2'd0, 3'd5, 1'b1, 1'b1},
    {6'h10, 2'd0, 3'd6, 1'b1, 1'b1},
    {6'h12, 2'd0, 3'd1, 1'b1, 1'b1}
  };

  function automatic logic [31:0] vec_target(input logic [31:0] num, input logic [2:0] vs);
    if (vs == 3'd0) return BASE;
    return BASE + (num << (vs + 2));
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1;
    step();
    step();
    rst = 0;
    m_ba = '0; m_bi = '0; m_ret = '0;
  endtask

  task automatic ctl(input logic [1:0] plv, input logic ie, input logic [2:0] vs,
                     input logic [NIRQ-1:0] lie);
    ctl_wr = 1; ctl_plv = plv; ctl_ie = ie; ctl_vs = vs; ctl_lie = lie;
    step();
    ctl_wr = 0;
  endtask

  task automatic request(input logic [5:0] mj, input logic [1:0] sb, input logic rf,
                         input logic [31:0] pc, input logic [31:0] insn);
    exc_valid = 1; exc_major = mj; exc_sub = sb; exc_refill = rf;
    cur_pc = pc; fault_insn = insn;
    step();
    exc_valid = 0; exc_refill = 0;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R12 reset values
    chk("R12 reset pc", redirect_pc, 32'h1C00_0000);
    chk("R12 plv/ie", {mode_plv, mode_ie}, 3'b000);
    chk("R12 da/pg", {mode_da, mode_pg}, 2'b10);
    chk("R12 datf/datm", {mode_datf, mode_datm}, 4'b0101);
    chk("R12 vs/mask", {vec_size, irq_mask}, '0);
    chk("R12 refill/debug flags", {rf_active, dbg_active, redirect_valid}, 3'b000);

    // table walk: R5 R6 R8 R11
    for (int i = 0; i < 16; i++) begin
      logic [5:0] mj;
      logic [1:0] sb;
      logic [2:0] vs;
      logic [31:0] pc;
      logic [31:0] insn;
      mj = TBL[i][12:7]; sb = TBL[i][6:5]; vs = TBL[i][4:2];
      pc = 32'h0000_1000 + 32'(i) * 16;
      insn = 32'hA500_0000 | 32'(i);
      ctl(2'(i % 4), 1'b0, vs, '0);
      request(mj, sb, 1'b0, pc, insn);
      if (TBL[i][1]) m_ba = pc;
      if (TBL[i][0]) m_bi = insn;
      chk("R8 redirect pulse", redirect_valid, 1);
      chk("R5 exception target", redirect_pc, vec_target(32'(mj), vs));
      chk("R6 cause", {cause_major, cause_sub}, {mj, sb});
      chk("R6 ret_pc", ret_pc, pc);
      chk("R6 saved plv/ie", {save_plv, save_ie}, {2'(i % 4), 1'b0});
      chk("R8 mode cleared", {mode_plv, mode_ie}, 3'b000);
      chk("R11 bad_addr", bad_addr, m_ba);
      chk("R11 bad_insn", bad_insn, m_bi);
    end
    m_ret = ret_pc;

    // R1 R2 masking and enable gating
    cur_pc = 32'h0000_4000;
    irq_in = 13'h0005;
    step();
    chk("R2 status follows lines", irq_status, 13'h0005);
    chk("R1 no entry with enable 0", redirect_valid, 0);
    ctl(2'd2, 1'b1, 3'd2, 13'h0010);
    step();
    chk("R2 masked lines not taken", redirect_valid, 0);
    ctl(2'd2, 1'b1, 3'd2, 13'h1FFF);
    step();
    chk("R5 irq target", redirect_pc, vec_target(32'd66, 3'd2));
    chk("R5 irq cause", {cause_major, cause_sub}, 8'h00);
    chk("R6 irq saved mode", {save_plv, save_ie}, 3'b101);
    chk("R6 irq ret", ret_pc, 32'h0000_4000);
    chk("R8 irq clears ie", {mode_plv, mode_ie}, 3'b000);
    chk("R11 irq keeps bad_insn", bad_insn, m_bi);
    step();
    chk("R8 pulse is one cycle", redirect_valid, 0);

    // R3 highest-numbered line
    irq_in = 13'h1001;
    step();
    ctl(2'd0, 1'b1, 3'd1, 13'h1FFF);
    step();
    chk("R3 top line wins", redirect_pc, vec_target(32'd76, 3'd1));
    // R4 zero spacing
    ctl(2'd0, 1'b1, 3'd0, 13'h1FFF);
    step();
    chk("R4 size 0 gives base", redirect_pc, BASE);
    irq_in = '0;
    step();
    step();
    m_ret = ret_pc;

    // R7 refill route
    ctl(2'd1, 1'b1, 3'd3, 13'h1FFF);
    request(6'h01, 2'd0, 1'b1, 32'h8000_1234, 32'h1111_2222);
    chk("R7 refill target", redirect_pc, RBASE);
    chk("R7 refill return", rf_ret_pc, 30'(32'h8000_1234 >> 2));
    chk("R7 refill saved mode", {rf_save_plv, rf_save_ie}, 3'b011);
    chk("R7 da/pg/flag", {mode_da, mode_pg, rf_active}, 3'b101);
    chk("R7 ordinary ret untouched", ret_pc, m_ret);

    // R13 unsupported requests
    m_ret = ret_pc;
    request(6'h2A, 2'd0, 1'b0, 32'h0000_7000, 32'h0);
    chk("R13 error pulse", {req_error, redirect_valid}, 2'b10);
    chk("R13 ret untouched", ret_pc, m_ret);
    request(6'h08, 2'd2, 1'b0, 32'h0000_7100, 32'h0);
    chk("R13 bad subcode", {req_error, redirect_valid}, 2'b10);
    chk("R13 cause untouched", {cause_major, cause_sub}, 8'h00);

    // R9 debug breakpoint
    do_reset();
    request(6'h3F, 2'd0, 1'b0, 32'h0000_5550, 32'h0);
    chk("R9 debug target", redirect_pc, BASE + 32'h480);
    chk("R9 debug flags", {dbg_active, dbg_cause, dbg_irq}, 3'b110);
    chk("R9 debug code", dbg_code, 6'h0C);
    chk("R9 debug return", dbg_ret_pc, 32'h0000_5550);

    // R10 interrupt in debug mode
    irq_in = 13'h0002;
    cur_pc = 32'h0000_6660;
    step();
    ctl(2'd3, 1'b1, 3'd2, 13'h1FFF);
    step();
    chk("R10 debug irq target", redirect_pc, BASE + 32'h480);
    chk("R10 debug irq flag", dbg_irq, 1);
    chk("R10 debug irq return", dbg_ret_pc, 32'h0000_6660);
    chk("R1 no ordinary entry in debug", ret_pc, 32'h0);
    chk("R8 debug irq clears mode", {mode_plv, mode_ie}, 3'b000);
    irq_in = '0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule